// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block drives a multiplexed liquid-crystal panel that has four common electrodes and forty segment electrodes. It runs at one-quarter duty with one-third bias. A host writes display bytes into a write-only latch array over a simple byte-write port. Each common owns its own stride of eight addresses, and only the first five addresses of each stride are backed by storage. Every cycle, each electrode output carries a 2-bit code that picks one of four bias voltages (0 ground, 1 one-third, 2 two-thirds, 3 full). An analog switch network outside the block turns that code into a voltage.

Timing comes from a 32.768 kHz tick. The block divides the tick into 256 Hz common slots, so four slots make one 64 Hz frame. The drive polarity flips on every frame so that the panel sees no net DC. A display-enable input blanks the panel by forcing every output to ground. A separate select input takes the top eight segments (32 to 39) out of display use for general I/O, and their drive is then held at ground.

Top module: `lcd_mux_driver`

## Requirements
- R1: After a synchronous active-low reset, all latch bytes are zero, common 0 is the scanned common and the polarity is normal. With the display enabled, common 0 then outputs code 3, commons 1 to 3 output code 1, and every segment outputs code 2.
- R2: A write to address 8n+b (n in 0..3, b in 0..4) stores the data byte for common n. Bit k of that byte controls segment 8b+k.
- R3: A write to any address whose low three bits are 5, 6 or 7 changes no stored bit, so no segment output of any common changes.
- R4: The scanned common advances by one, in the order 0,1,2,3,0, only after 128 tick pulses have been counted since the previous advance.
- R5: The drive polarity toggles each time the scan wraps from common 3 back to common 0, which is once every 64 Hz frame.
- R6: With normal polarity and the display enabled, the scanned common outputs 3 and the other commons output 1. A segment whose bit is set outputs 0, and a segment whose bit is clear outputs 2.
- R7: With inverted polarity and the display enabled, the scanned common outputs 0 and the other commons output 2. A segment whose bit is set outputs 3, and a segment whose bit is clear outputs 1.
- R8: While the display enable is low, every common and segment output is code 0.
- R9: While the I/O select is high, segments 32 to 39 output code 0 and all other outputs are unaffected.
- R10: The segment outputs always follow the latch bits of the currently scanned common.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse at 32.768 kHz |
| wr_en | input | 1 | Latch write strobe |
| wr_addr | input | 5 | Latch byte address |
| wr_data | input | 8 | Latch write data |
| disp_en | input | 1 | Display enable; low blanks the panel |
| seg_io_sel | input | 1 | High hands segments 32..39 to general I/O |
| com_lvl | output | 8 | Common drive codes, 2 bits per common, common 0 in bits 1:0 |
| seg_lvl | output | 80 | Segment drive codes, 2 bits per segment, segment 0 in bits 1:0 |

## Verification
The assertions expect the tick to be a pulse that is sampled once per clock. They also expect the address and data inputs to be meaningful only while the write strobe is high. The stimulus holds to both by driving every input once per cycle at the falling edge. Random ticks arrive at a high density so that several full frames and polarity flips occur. Random writes cover the whole 5-bit address space, including the unbacked offsets, and the enable and I/O-select inputs toggle randomly between writes so that blanking and suppression are seen in both polarities.

// File: rtl/lcd_pkg.sv
// Package: shared drive-level codes for the LCD scanner.
// Assumes an external analog switch maps each code to a bias rail.
package lcd_pkg;
    typedef enum logic [1:0] {
        LVL_GND       = 2'd0,
        LVL_THIRD     = 2'd1,
        LVL_TWO_THIRD = 2'd2,
        LVL_FULL      = 2'd3
    } lvl_e;
endpackage

// File: rtl/lcd_latch_array.sv
// Write-only display latch array. Each common owns an 8-address stride.
// Only the first BYTES offsets of a stride hold storage; the rest are dropped.
// Assumes wr_addr and wr_data are valid while wr_en is high.
module lcd_latch_array #(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 40,
    parameter int ADDR_W  = 5,
    parameter int CW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [CW-1:0]      com_sel,
    output logic [NUM_SEG-1:0] row_bits
);
    localparam int BYTES = (NUM_SEG + 7) / 8;

    logic [NUM_COM-1:0][BYTES-1:0][7:0] mem;
    logic [ADDR_W-4:0] wr_com;
    logic [2:0]        wr_byte;
    logic [BYTES*8-1:0] row_full;

    assign wr_com  = wr_addr[ADDR_W-1:3];
    assign wr_byte = wr_addr[2:0];

    // Store a written byte when its address lands on a backed location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NUM_COM; c++) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (int'(wr_com) == c && int'(wr_byte) == b)
                        mem[c][b] <= wr_data;
                end
            end
        end
    end

    // Present the bits of the common being scanned.
    assign row_full = mem[com_sel];
    assign row_bits = row_full[NUM_SEG-1:0];

    // R3: writes to unbacked offsets leave the array untouched.
    assert_unbacked_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr[2:0]) >= BYTES) |=> $stable(mem));
endmodule

// File: rtl/lcd_scan_timer.sv
// Divides the 32.768 kHz tick into common slots. It steps the scanned common
// and flips the drive polarity at every frame wrap.
// Assumes tick is a single-cycle pulse.
module lcd_scan_timer #(
    parameter int NUM_COM        = 4,
    parameter int TICKS_PER_SLOT = 128,
    parameter int CW             = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] com_idx,
    output logic          inv
);
    localparam int TW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;

    logic [TW-1:0] tick_cnt;
    logic          slot_end;

    assign slot_end = tick && (int'(tick_cnt) == TICKS_PER_SLOT - 1);

    // Count ticks inside the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)         tick_cnt <= '0;
        else if (slot_end)  tick_cnt <= '0;
        else if (tick)      tick_cnt <= tick_cnt + 1'b1;
    end

    // Advance the common at the end of a slot and flip polarity on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com_idx <= '0;
            inv     <= 1'b0;
        end else if (slot_end) begin
            if (int'(com_idx) == NUM_COM - 1) begin
                com_idx <= '0;
                inv     <= ~inv;
            end else begin
                com_idx <= com_idx + 1'b1;
            end
        end
    end

    // R4: the common only steps forward by one, wrapping after the last.
    assert_com_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (com_idx != $past(com_idx)) |->
        ((int'($past(com_idx)) == NUM_COM - 1) ? (com_idx == '0)
                                               : (com_idx == $past(com_idx) + 1'b1)));

    // R4: a step happens only on a cycle that carried a tick.
    assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (com_idx != $past(com_idx)) |-> $past(tick));

    // R5: polarity flips only together with a wrap to common 0.
    assert_inv_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv != $past(inv)) |-> (com_idx == '0 && int'($past(com_idx)) == NUM_COM - 1));
endmodule

// File: rtl/lcd_level_encoder.sv
// Turns the scan state and latch row into per-electrode bias codes.
// Pure combinational logic. Segments from IO_FIRST upward can be handed to I/O.
module lcd_level_encoder
    import lcd_pkg::*;
#(
    parameter int NUM_COM  = 4,
    parameter int NUM_SEG  = 40,
    parameter int IO_FIRST = 32,
    parameter int CW       = 2
) (
    input  logic [CW-1:0]        com_idx,
    input  logic                 inv,
    input  logic                 disp_en,
    input  logic                 seg_io_sel,
    input  logic [NUM_SEG-1:0]   row_bits,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    genvar c, s;

    // One lane per common: selected at full/ground, others at the 1/3-side rail.
    for (c = 0; c < NUM_COM; c++) begin : g_com
        lvl_e lv;
        always_comb begin
            if (!disp_en)                lv = LVL_GND;
            else if (int'(com_idx) == c) lv = inv ? LVL_GND : LVL_FULL;
            else                         lv = inv ? LVL_TWO_THIRD : LVL_THIRD;
        end
        assign com_lvl[2*c +: 2] = lv;
    end

    // One lane per segment: on opposes the selected common, off sits mid-rail.
    for (s = 0; s < NUM_SEG; s++) begin : g_seg
        lvl_e lv;
        always_comb begin
            if (!disp_en || (s >= IO_FIRST && seg_io_sel)) lv = LVL_GND;
            else if (row_bits[s])                          lv = inv ? LVL_FULL : LVL_GND;
            else                                           lv = inv ? LVL_THIRD : LVL_TWO_THIRD;
        end
        assign seg_lvl[2*s +: 2] = lv;
    end
endmodule

// File: rtl/lcd_mux_driver.sv
// Top of the multiplexed LCD scanner: latch array, slot timer and level encoder.
// Assumes tick_32k is a one-cycle pulse synchronous to clk.
module lcd_mux_driver #(
    parameter int NUM_COM        = 4,
    parameter int NUM_SEG        = 40,
    parameter int IO_FIRST       = 32,
    parameter int TICKS_PER_SLOT = 128,
    parameter int ADDR_W         = $clog2(NUM_COM) + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_32k,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 disp_en,
    input  logic                 seg_io_sel,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    localparam int CW = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

    logic [CW-1:0]      com_idx;
    logic               inv;
    logic [NUM_SEG-1:0] row_bits;

    lcd_scan_timer #(.NUM_COM(NUM_COM), .TICKS_PER_SLOT(TICKS_PER_SLOT), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .com_idx(com_idx), .inv(inv)
    );

    lcd_latch_array #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .CW(CW)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .com_sel(com_idx), .row_bits(row_bits)
    );

    lcd_level_encoder #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .IO_FIRST(IO_FIRST), .CW(CW)) u_enc (
        .com_idx(com_idx), .inv(inv), .disp_en(disp_en), .seg_io_sel(seg_io_sel),
        .row_bits(row_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // R8: a blanked panel drives ground on every electrode.
    assert_blank_ground_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (com_lvl == '0 && seg_lvl == '0));

    // R9: segments handed to I/O carry no drive.
    assert_io_suppressed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_io_sel |-> (seg_lvl[2*NUM_SEG-1:2*IO_FIRST] == '0));

    // R6: with normal polarity the scanned common sits at the full rail.
    assert_sel_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !inv) |-> (com_lvl[2*com_idx +: 2] == 2'd3));

    // R7: with inverted polarity the scanned common sits at ground.
    assert_sel_gnd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && inv) |-> (com_lvl[2*com_idx +: 2] == 2'd0));
endmodule

// File: tb/lcd_mux_driver_test.sv
module lcd_mux_driver_test;
    localparam int NC = 4, NS = 40, TPS = 128;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic disp_en = 1'b1, io_sel = 1'b0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_mem [NC][5];
    int m_com = 0, m_cnt = 0;
    bit m_inv = 0;

    always #5 clk = ~clk;

    lcd_mux_driver uut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .disp_en(disp_en), .seg_io_sel(io_sel),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [2*NC-1:0] exp_com();
        logic [2*NC-1:0] v = '0;
        for (int c = 0; c < NC; c++) begin
            if (!disp_en)       v[2*c +: 2] = 2'd0;
            else if (c == m_com) v[2*c +: 2] = m_inv ? 2'd0 : 2'd3;
            else                v[2*c +: 2] = m_inv ? 2'd2 : 2'd1;
        end
        return v;
    endfunction

    function automatic logic [2*NS-1:0] exp_seg();
        logic [2*NS-1:0] v = '0;
        for (int s = 0; s < NS; s++) begin
            logic on = m_mem[m_com][s/8][s%8];
            if (!disp_en || (s >= 32 && io_sel)) v[2*s +: 2] = 2'd0;
            else if (on)                         v[2*s +: 2] = m_inv ? 2'd3 : 2'd0;
            else                                 v[2*s +: 2] = m_inv ? 2'd1 : 2'd2;
        end
        return v;
    endfunction

    task automatic check(string req, logic [2*NS-1:0] act, logic [2*NS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, let one edge pass, update the model, compare.
    task automatic step(bit en, logic [4:0] a, logic [7:0] d, bit tk, bit de, bit io);
        wr_en = en; wr_addr = a; wr_data = d; tick = tk; disp_en = de; io_sel = io;
        @(posedge clk);
        @(negedge clk);
        if (en && a[2:0] < 3'd5) m_mem[a[4:3]][a[2:0]] = d;
        if (tk) begin
            if (m_cnt == TPS - 1) begin
                m_cnt = 0;
                if (m_com == NC - 1) begin m_com = 0; m_inv = ~m_inv; end
                else m_com++;
            end else m_cnt++;
        end
    endtask

    function automatic string tag();
        if (!disp_en) return "R8";
        if (io_sel)   return "R9";
        return m_inv ? "R7" : "R6";
    endfunction

    task automatic compare_all(string req);
        check(req, {{(2*NS-2*NC){1'b0}}, com_lvl}, {{(2*NS-2*NC){1'b0}}, exp_com()});
        check({req, "/R10"}, seg_lvl, exp_seg());
    endtask

    task automatic advance_slot();
        for (int i = 0; i < TPS; i++) step(0, '0, '0, 1, 1, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < NC; c++) for (int b = 0; b < 5; b++) m_mem[c][b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 com", {72'h0, com_lvl}, {72'h0, 8'h57});
        check("R1 seg", seg_lvl, {NS{2'b10}});

        // R2: bit 0 of address 0 is segment 0 of common 0
        step(1, 5'h00, 8'h01, 0, 1, 0);
        check("R2 seg0", {78'h0, seg_lvl[1:0]}, 80'h0);
        // R2: bit 7 of address 0x0C is segment 39 of common 1
        step(1, 5'h0C, 8'h80, 0, 1, 0);
        // R3: unbacked offset in common 1's stride
        step(1, 5'h0D, 8'hFF, 0, 1, 0);
        step(1, 5'h1F, 8'hFF, 0, 1, 0);

        // R4: 127 ticks keep common 0
        for (int i = 0; i < TPS - 1; i++) step(0, '0, '0, 1, 1, 0);
        check("R4 hold", {72'h0, com_lvl}, {72'h0, 8'h57});
        step(0, '0, '0, 1, 1, 0);
        check("R4 step", {72'h0, com_lvl}, {72'h0, 8'h5D});
        check("R2 seg39", {78'h0, seg_lvl[79:78]}, 80'h0);
        check("R3 others", {2'b0, seg_lvl[77:0]}, {2'b0, {39{2'b10}}});
        compare_all("R3");

        // R5: finish the frame; polarity inverts at common 0
        advance_slot(); advance_slot();
        check("R4 com3", {72'h0, com_lvl}, {72'h0, 8'hD5});
        advance_slot();
        check("R5 inv", {72'h0, com_lvl}, {72'h0, 8'hA8});
        check("R7 seg0", {78'h0, seg_lvl[1:0]}, {78'h0, 2'd3});
        check("R7 seg1", {78'h0, seg_lvl[3:2]}, {78'h0, 2'd1});

        // R8 / R9 directed
        step(0, '0, '0, 0, 0, 0);
        check("R8 blank", seg_lvl | {72'h0, com_lvl}, 80'h0);
        step(1, 5'h04, 8'hFF, 0, 1, 1);
        check("R9 io", {64'h0, seg_lvl[79:64]}, 80'h0);
        compare_all("R9");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            bit en = ($urandom % 4) == 0;
            logic [4:0] a = 5'($urandom);
            logic [7:0] d = 8'($urandom);
            bit tk = ($urandom % 4) != 0;
            bit de = ($urandom % 8) != 0;
            bit io = ($urandom % 4) == 0;
            step(en, a, d, tk, de, io);
            compare_all(tag());
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule